// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block lets a host on an 8-bit I/O bus program a set of configuration registers through two adjacent byte ports. The lower port, at the base address, takes key bytes and the register index. The upper port, at base plus one, moves data to and from the register that the index selects. The base address comes from a separate decoder as an input. The bus handshake and the logical devices themselves are not part of this block.

Access is locked by default. The host writes an entry key to the lower port to open it, and from then on index and data accesses work until it writes an exit key. Indices below 30h are shared globals: a logical-device selector, read-only identification bytes and a mode register with a serial-interrupt enable. Indices from 30h up form a bank that belongs to the currently selected logical device. Each implemented device has an activate flag and a small window of general byte registers in its bank. Read data is combinational in the cycle where the read strobe is high. A write takes effect at the next rising clock edge.

Top module: `kcfg_port`

## Requirements
- R1: While locked, a write of 55h to the base address opens configuration access, and `cfg_open` is 1 after that edge. While open, a write of AAh to the base address locks access again and leaves the index unchanged. Only these two key writes change `cfg_open`.
- R2: While locked, writes to either port other than the entry key change no register. Reads of either port return FFh with `rd_hit` at 0.
- R3: While open, a write of any value other than AAh to the base address loads the index register. A read of the base address returns the current index with `rd_hit` at 1.
- R4: Global index 07h holds an 8-bit logical device number, which is readable and writable and resets to 00h. This number selects the bank that indices 30h–FFh reach.
- R5: Indices 00h–2Fh reach the same registers whatever logical device is selected. Reserved globals (every global index not named in R4, R6 or R8) read 00h and ignore writes.
- R6: Global indices 1Ch, 1Dh, 1Eh, 1Fh and 20h read fixed identification bytes. With the default parameters these are 03h, 21h, 5Ah, C3h and FEh. Writes to these indices change nothing.
- R7: In each implemented device bank, index 30h is the activate register. Only bit 0 is stored, bits 7:1 read 0, and the flag resets to 0. The flag for device n appears on `dev_active[n]`.
- R8: Global index 24h holds the serial-interrupt enable in bit 2, which resets to 1 and appears on `sirq_en`. The other bits of 24h read 0 and are not stored.
- R9: Each implemented device owns WIN_REGS byte registers at indices 31h onward (31h–34h by default). They reset to 00h, are read/write, and are separate for every device.
- R10: Bank indices that are undefined (above the window), and every bank index when the selected device number is NUM_LDN or above (8 by default), read FFh and ignore writes.
- R11: After reset, access is locked, the index and device number are 00h, all activate flags are 0 and `sirq_en` is 1.
- R12: Accesses to addresses other than the base address and the base address plus one are not claimed: `rd_hit` is 0, the read data is FFh, and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_base | input | 16 | Base I/O address from the address decoder |
| io_addr | input | 16 | Address of the current bus access |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while `io_rd` is high |
| rd_hit | output | 1 | The current read is claimed by this block |
| cfg_open | output | 1 | Configuration access is open |
| dev_active | output | NUM_LDN | Activate flag of each logical device |
| sirq_en | output | 1 | Serial-interrupt enable from the mode register |

## Verification
The assertions check the following on every cycle:
- The lock changes state only on the two key writes.
- The index holds while locked.
- The device number, the interrupt enable and each activate flag change only on a write aimed at their own index.
- At most one device bank is written at a time.
- Unclaimed addresses read FFh.

Other behaviour needs the bench's scenarios:
- The read values of identification, reserved and undefined indices.
- The separation of the windows of different devices.
- Globals reading the same in every bank.
- The handling of device numbers beyond the implemented range.

The bench shows these by comparing every read against a model of the register file, both over long random access streams and in directed cases.

// File: rtl/kcfg_pkg.sv
package kcfg_pkg;

  localparam logic [7:0] KEY_ENTER = 8'h55;
  localparam logic [7:0] KEY_EXIT  = 8'hAA;

  localparam logic [7:0] IDX_LDN   = 8'h07;
  localparam logic [7:0] IDX_REV   = 8'h1C;
  localparam logic [7:0] IDX_SUB   = 8'h1D;
  localparam logic [7:0] IDX_IDLO  = 8'h1E;
  localparam logic [7:0] IDX_IDHI  = 8'h1F;
  localparam logic [7:0] IDX_LEG   = 8'h20;
  localparam logic [7:0] IDX_MODE  = 8'h24;
  localparam logic [7:0] IDX_BANK  = 8'h30;
  localparam logic [7:0] IDX_ACT   = 8'h30;
  localparam logic [7:0] IDX_WIN0  = 8'h31;

  localparam int SIRQ_BIT = 2;

  typedef enum logic [1:0] {
    PORT_NONE = 2'd0,
    PORT_IDX  = 2'd1,
    PORT_DAT  = 2'd2
  } port_e;

  typedef enum logic [1:0] {
    SLOT_ACT  = 2'd0,
    SLOT_WIN  = 2'd1,
    SLOT_UNDEF = 2'd2
  } slot_e;

  // Which of the two ports an address hits, given the decoder's base.
  function automatic port_e port_of(input logic [15:0] addr,
                                    input logic [15:0] base);
    logic [15:0] upper;
    upper = base + 16'd1;
    if (addr == base)       return PORT_IDX;
    else if (addr == upper) return PORT_DAT;
    else                    return PORT_NONE;
  endfunction

  function automatic logic is_global(input logic [7:0] idx);
    return idx < IDX_BANK;
  endfunction

  // Kind of bank register an index selects for a window of win bytes.
  function automatic slot_e bank_slot(input logic [7:0] idx, input int win);
    int off;
    off = int'(idx) - int'(IDX_WIN0);
    if (idx == IDX_ACT)               return SLOT_ACT;
    else if (off >= 0 && off < win)   return SLOT_WIN;
    else                              return SLOT_UNDEF;
  endfunction

  function automatic int win_offset(input logic [7:0] idx);
    return int'(idx) - int'(IDX_WIN0);
  endfunction

endpackage

// File: rtl/kcfg_key_lock.sv
module kcfg_key_lock
  import kcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_port_wr,
  input  logic [7:0] wdata,
  output logic       open_q,
  output logic       enter_ev,
  output logic       exit_ev,
  output logic       idx_load_ev
);

  always_comb begin
    enter_ev    = idx_port_wr && !open_q && (wdata == KEY_ENTER);
    exit_ev     = idx_port_wr &&  open_q && (wdata == KEY_EXIT);
    idx_load_ev = idx_port_wr &&  open_q && (wdata != KEY_EXIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        open_q <= 1'b0;
    else if (enter_ev) open_q <= 1'b1;
    else if (exit_ev)  open_q <= 1'b0;
  end

  AST_ENTER_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && idx_port_wr && wdata == KEY_ENTER) |=> open_q); // R1
  AST_EXIT_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && idx_port_wr && wdata == KEY_EXIT) |=> !open_q); // R1
  AST_LOCK_ONLY_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (!(idx_port_wr && wdata == KEY_ENTER)) && (!(idx_port_wr && wdata == KEY_EXIT))
      |=> $stable(open_q)); // R1

endmodule

// File: rtl/kcfg_globals.sv
module kcfg_globals
  import kcfg_pkg::*;
#(
  parameter logic [7:0] ID_REV    = 8'h03,
  parameter logic [7:0] ID_SUB    = 8'h21,
  parameter logic [7:0] ID_LO     = 8'h5A,
  parameter logic [7:0] ID_HI     = 8'hC3,
  parameter logic [7:0] ID_LEGACY = 8'hFE
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ev,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] rd_byte,
  output logic [7:0] ldn_q,
  output logic       sirq_q
);

  logic ldn_wr_ev;
  logic mode_wr_ev;

  always_comb begin
    ldn_wr_ev  = wr_ev && (idx == IDX_LDN);
    mode_wr_ev = wr_ev && (idx == IDX_MODE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ldn_q  <= 8'h00;
      sirq_q <= 1'b1;
    end else begin
      if (ldn_wr_ev)  ldn_q  <= wdata;
      if (mode_wr_ev) sirq_q <= wdata[SIRQ_BIT];
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    case (idx)
      IDX_LDN:  rd_byte = ldn_q;
      IDX_REV:  rd_byte = ID_REV;
      IDX_SUB:  rd_byte = ID_SUB;
      IDX_IDLO: rd_byte = ID_LO;
      IDX_IDHI: rd_byte = ID_HI;
      IDX_LEG:  rd_byte = ID_LEGACY;
      IDX_MODE: rd_byte[SIRQ_BIT] = sirq_q;
      default:  rd_byte = 8'h00;
    endcase
  end

  AST_LDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ev && idx == IDX_LDN) |=> $stable(ldn_q)); // R4
  AST_SIRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ev && idx == IDX_MODE) |=> $stable(sirq_q)); // R8

endmodule

// File: rtl/kcfg_dev_bank.sv
module kcfg_dev_bank
  import kcfg_pkg::*;
#(
  parameter int WIN_REGS = 4
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ev,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] rd_byte,
  output logic       act_q
);

  localparam int WIN_W = (WIN_REGS > 1) ? $clog2(WIN_REGS) : 1;

  logic [7:0]       win_q [WIN_REGS];
  slot_e            slot;
  logic [WIN_W-1:0] woff;
  logic             act_wr_ev;
  logic             win_wr_ev;

  always_comb begin
    slot      = bank_slot(idx, WIN_REGS);
    woff      = WIN_W'(win_offset(idx));
    act_wr_ev = wr_ev && (slot == SLOT_ACT);
    win_wr_ev = wr_ev && (slot == SLOT_WIN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      for (int i = 0; i < WIN_REGS; i++) win_q[i] <= 8'h00;
    end else begin
      if (act_wr_ev) act_q <= wdata[0];
      if (win_wr_ev) win_q[woff] <= wdata;
    end
  end

  always_comb begin
    case (slot)
      SLOT_ACT: rd_byte = {7'b0, act_q};
      SLOT_WIN: rd_byte = win_q[woff];
      default:  rd_byte = 8'hFF;
    endcase
  end

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ev && idx == IDX_ACT) |=> $stable(act_q)); // R7
  AST_UNDEF_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && slot == SLOT_UNDEF) |=> $stable(act_q)); // R10

endmodule

// File: rtl/kcfg_port.sv
module kcfg_port
  import kcfg_pkg::*;
#(
  parameter int         NUM_LDN   = 8,
  parameter int         WIN_REGS  = 4,
  parameter logic [7:0] ID_REV    = 8'h03,
  parameter logic [7:0] ID_SUB    = 8'h21,
  parameter logic [7:0] ID_LO     = 8'h5A,
  parameter logic [7:0] ID_HI     = 8'hC3,
  parameter logic [7:0] ID_LEGACY = 8'hFE
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [15:0]        io_base,
  input  logic [15:0]        io_addr,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic [7:0]         io_wdata,
  output logic [7:0]         io_rdata,
  output logic               rd_hit,
  output logic               cfg_open,
  output logic [NUM_LDN-1:0] dev_active,
  output logic               sirq_en
);

  localparam int LDN_W = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;

  port_e        port;
  logic         idx_port_wr;
  logic         enter_ev;
  logic         exit_ev;
  logic         idx_load_ev;
  logic         data_wr_ev;
  logic         glb_wr_ev;
  logic [7:0]   index_q;
  logic [7:0]   ldn_q;
  logic [7:0]   glb_rd;
  logic         ldn_valid;
  logic [NUM_LDN-1:0] bank_wr_vec;
  logic [7:0]   bank_rd [NUM_LDN];
  logic [7:0]   sel_bank_rd;

  always_comb begin
    port        = port_of(io_addr, io_base);
    idx_port_wr = io_wr && (port == PORT_IDX);
    data_wr_ev  = io_wr && (port == PORT_DAT) && cfg_open;
    glb_wr_ev   = data_wr_ev && is_global(index_q);
    ldn_valid   = int'(ldn_q) < NUM_LDN;
  end

  kcfg_key_lock u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .idx_port_wr (idx_port_wr),
    .wdata       (io_wdata),
    .open_q      (cfg_open),
    .enter_ev    (enter_ev),
    .exit_ev     (exit_ev),
    .idx_load_ev (idx_load_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           index_q <= 8'h00;
    else if (idx_load_ev) index_q <= io_wdata;
  end

  kcfg_globals #(
    .ID_REV    (ID_REV),
    .ID_SUB    (ID_SUB),
    .ID_LO     (ID_LO),
    .ID_HI     (ID_HI),
    .ID_LEGACY (ID_LEGACY)
  ) u_glb (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ev   (glb_wr_ev),
    .idx     (index_q),
    .wdata   (io_wdata),
    .rd_byte (glb_rd),
    .ldn_q   (ldn_q),
    .sirq_q  (sirq_en)
  );

  for (genvar d = 0; d < NUM_LDN; d++) begin : g_bank
    assign bank_wr_vec[d] = data_wr_ev && !is_global(index_q) && (ldn_q == 8'(d));
    kcfg_dev_bank #(.WIN_REGS(WIN_REGS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ev   (bank_wr_vec[d]),
      .idx     (index_q),
      .wdata   (io_wdata),
      .rd_byte (bank_rd[d]),
      .act_q   (dev_active[d])
    );
  end

  always_comb begin
    sel_bank_rd = ldn_valid ? bank_rd[ldn_q[LDN_W-1:0]] : 8'hFF;
  end

  always_comb begin
    rd_hit   = io_rd && cfg_open && (port != PORT_NONE);
    io_rdata = 8'hFF;
    if (rd_hit) begin
      if (port == PORT_IDX)        io_rdata = index_q;
      else if (is_global(index_q)) io_rdata = glb_rd;
      else                         io_rdata = sel_bank_rd;
    end
  end

  AST_LOCKED_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> $stable(index_q)); // R2
  AST_EXIT_KEEPS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    exit_ev |=> $stable(index_q)); // R1
  AST_ONE_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_wr_vec)); // R9
  AST_OFFPORT_UNCLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && port == PORT_NONE) |-> (io_rdata == 8'hFF)); // R12
  AST_LOCKED_NO_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |-> (bank_wr_vec == '0)); // R2

endmodule

// File: tb/kcfg_port_test.sv
module kcfg_port_test;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;
  localparam int WN = 4;
  localparam logic [15:0] BASE = 16'h004E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_base = BASE;
  logic [15:0] io_addr = 16'h0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata;
  logic        rd_hit;
  logic        cfg_open;
  logic [NL-1:0] dev_active;
  logic        sirq_en;

  int n_checks = 0;
  int n_fail = 0;

  // reference model state
  logic       m_open;
  logic [7:0] m_idx;
  logic [7:0] m_ldn;
  logic       m_sirq;
  logic [NL-1:0] m_act;
  logic [7:0] m_win [NL][WN];

  always #(CLK_PERIOD/2) clk = ~clk;

  kcfg_port uut (
    .clk(clk), .rst_n(rst_n), .io_base(io_base), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .rd_hit(rd_hit), .cfg_open(cfg_open), .dev_active(dev_active), .sirq_en(sirq_en)
  );

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_open = 0; m_idx = 0; m_ldn = 0; m_sirq = 1; m_act = '0;
    for (int d = 0; d < NL; d++) for (int w = 0; w < WN; w++) m_win[d][w] = 8'h00;
  endtask

  function automatic logic [7:0] exp_reg(input logic [7:0] i);
    if (i < 8'h30) begin
      case (i)
        8'h07: return m_ldn;
        8'h1C: return 8'h03;
        8'h1D: return 8'h21;
        8'h1E: return 8'h5A;
        8'h1F: return 8'hC3;
        8'h20: return 8'hFE;
        8'h24: return m_sirq ? 8'h04 : 8'h00;
        default: return 8'h00;
      endcase
    end
    if (int'(m_ldn) >= NL) return 8'hFF;
    if (i == 8'h30) return {7'b0, m_act[m_ldn[2:0]]};
    if (i >= 8'h31 && int'(i) < 8'h31 + WN) return m_win[m_ldn[2:0]][int'(i) - 8'h31];
    return 8'hFF;
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    if (a == BASE) begin
      if (!m_open) begin
        if (d == 8'h55) m_open = 1;
      end else if (d == 8'hAA) m_open = 0;
      else m_idx = d;
    end else if (a == BASE + 16'd1 && m_open) begin
      if (m_idx < 8'h30) begin
        if (m_idx == 8'h07) m_ldn = d;
        if (m_idx == 8'h24) m_sirq = d[2];
      end else if (int'(m_ldn) < NL) begin
        if (m_idx == 8'h30) m_act[m_ldn[2:0]] = d[0];
        else if (m_idx >= 8'h31 && int'(m_idx) < 8'h31 + WN)
          m_win[m_ldn[2:0]][int'(m_idx) - 8'h31] = d;
      end
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
    model_write(a, d);
  endtask

  task automatic bus_read(input logic [15:0] a, input string req);
    logic [7:0] e;
    logic eh;
    @(negedge clk);
    io_addr = a; io_rd = 1;
    #1;
    eh = m_open && (a == BASE || a == BASE + 16'd1);
    e = !eh ? 8'hFF : (a == BASE) ? m_idx : exp_reg(m_idx);
    chk(req, io_rdata, e);
    chk({req, " hit"}, {7'b0, rd_hit}, {7'b0, eh});
    io_rd = 0;
  endtask

  task automatic chk_outs(input string req);
    chk({req, " open"}, {7'b0, cfg_open}, {7'b0, m_open});
    chk({req, " active"}, dev_active, m_act);
    chk({req, " sirq"}, {7'b0, sirq_en}, {7'b0, m_sirq});
  endtask

  task automatic cfg_wr(input logic [7:0] i, input logic [7:0] d);
    bus_write(BASE, i);
    bus_write(BASE + 16'd1, d);
  endtask

  task automatic cfg_rd(input logic [7:0] i, input string req);
    bus_write(BASE, i);
    bus_read(BASE + 16'd1, req);
  endtask

  initial begin
    model_reset();
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state
    chk_outs("R11");
    bus_read(BASE, "R11 locked index read");

    // R2 locked: nothing takes effect
    bus_write(BASE + 16'd1, 8'h3C);
    bus_write(BASE, 8'h07);
    bus_write(BASE, 8'hAA);
    bus_read(BASE, "R2 locked idx");
    bus_read(BASE + 16'd1, "R2 locked data");
    chk_outs("R2");

    // R1 entry
    bus_write(BASE, 8'h55);
    chk_outs("R1 enter");

    // R3 index load and readback
    bus_write(BASE, 8'h20);
    bus_read(BASE, "R3 index read");
    bus_read(BASE + 16'd1, "R6 legacy id");
    // R6 identification bytes, write ignored
    cfg_wr(8'h1C, 8'h11);
    cfg_rd(8'h1C, "R6 rev");
    cfg_rd(8'h1D, "R6 sub");
    cfg_rd(8'h1E, "R6 id lo");
    cfg_rd(8'h1F, "R6 id hi");

    // R8 serial interrupt enable
    cfg_rd(8'h24, "R8 default");
    cfg_wr(8'h24, 8'hFB);
    cfg_rd(8'h24, "R8 cleared");
    chk_outs("R8 clear");
    cfg_wr(8'h24, 8'hFF);
    cfg_rd(8'h24, "R8 set");
    chk_outs("R8 set");

    // R5 reserved global
    cfg_wr(8'h10, 8'h5A);
    cfg_rd(8'h10, "R5 reserved");

    // R4, R7, R9 bank selection
    cfg_wr(8'h07, 8'h03);
    cfg_rd(8'h07, "R4 ldn");
    cfg_wr(8'h30, 8'hFF);
    cfg_rd(8'h30, "R7 activate");
    chk_outs("R7");
    cfg_wr(8'h31, 8'hA5);
    cfg_wr(8'h34, 8'h3E);
    cfg_rd(8'h24, "R5 global in bank 3");
    cfg_wr(8'h07, 8'h05);
    cfg_rd(8'h31, "R9 other device");
    cfg_rd(8'h30, "R7 other device");
    cfg_wr(8'h07, 8'h03);
    cfg_rd(8'h31, "R9 window kept");
    cfg_rd(8'h34, "R9 last window");

    // R10 undefined and out-of-range
    cfg_wr(8'h35, 8'h12);
    cfg_rd(8'h35, "R10 undefined");
    cfg_wr(8'h07, 8'h09);
    cfg_wr(8'h30, 8'h01);
    cfg_rd(8'h30, "R10 ldn beyond");
    chk_outs("R10");

    // R12 off-port access
    bus_write(BASE + 16'd2, 8'h07);
    bus_read(BASE + 16'd2, "R12 off port");
    bus_read(BASE - 16'd1, "R12 below base");
    bus_read(BASE, "R12 index untouched");

    // R1 exit then locked data write has no effect
    bus_write(BASE, 8'hAA);
    chk_outs("R1 exit");
    bus_write(BASE + 16'd1, 8'h00);
    bus_write(BASE, 8'h55);
    bus_read(BASE, "R1 index kept across exit");
    cfg_rd(8'h07, "R2 ldn after locked write");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom_range(0, 9));
      d = 8'($urandom);
      case (op)
        0: bus_write(BASE, ($urandom_range(0, 1) == 0) ? 8'h55 : 8'hAA);
        1, 2: bus_write(BASE, 8'h07 + 8'($urandom_range(0, 1)) * 8'h29 + 8'($urandom_range(0, 6)));
        3: bus_write(BASE, 8'h1B + 8'($urandom_range(0, 10)));
        4: bus_write(BASE + 16'd1, (m_idx == 8'h07) ? 8'($urandom_range(0, 9)) : d);
        5: bus_write(BASE + 16'd1, d);
        6: bus_read(BASE, "R3 random index");
        7, 8: bus_read(BASE + 16'd1, "R9 random data");
        default: begin
          bus_write(BASE + 16'd3, d);
          bus_read(BASE + 16'd2, "R12 random off");
        end
      endcase
      if (n % 50 == 0) chk_outs("R1 random");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule